// File: doc/BRIEF.md
# Programmable DMA Channel Controller

This block is one memory-to-memory transfer channel. Software loads a source address, a destination address, a unit count and a 16-bit control word. Setting the enable bit arms the channel. After a short guard delay it waits for its chosen start condition: it starts at once, or on a vertical-blank or horizontal-blank event pulse.

Once started, the channel moves one unit at a time through a simple request/acknowledge bus master. Each unit is a read at the source address followed by a write of the same data to the destination address. A unit is a 16-bit halfword or a 32-bit word. After every unit, each address steps up, steps down or stays put, according to its own mode field.

When the last unit is written, the channel can pulse an interrupt request. In single-shot mode it then disables itself and puts its working addresses back to the values software last loaded. In repeat mode it stays armed and runs again on the next start event.

Top module: `dma_chan`

## Requirements
- R1: After synchronous active-low reset, the control readback is 0000h, and both bus_req and irq are low.
- R2: The control word holds: enable at bit 15, interrupt enable at bit 14, start select at bits 13:12, unit size at bit 11 (1 = 32-bit), repeat at bit 10, source mode at bits 9:8 and destination mode at bits 7:6. Bits 5:0 read back as 0, and all other bits read back as written.
- R3: A write that sets enable from 0 to 1 happens at clock edge E0. Start conditions sampled at the two edges after E0 are ignored. With start select 00, bus_req first goes high after the third edge after E0.
- R4: The start select codes are 00 = start at once, 01 = start when vblank_evt is sampled high, 10 = start when hblank_evt is sampled high. Code 11 never starts a transfer. An event input that the start select does not name has no effect.
- R5: Each unit is a read at the source (bus_we = 0) followed by a write at the destination (bus_we = 1) of the data that was read. The bus_wide output shows the unit size. For 16-bit units the data uses bits 15:0, and bus_wdata bits 31:16 are 0.
- R6: Address modes are 00 = add the unit size in bytes (2 or 4), 01 = subtract it, 10 = hold. Source mode 11 holds the source address. Destination mode 11 adds the unit size.
- R7: A count of N moves exactly N units. While bus_req is high and bus_ack is low, bus_req, bus_addr and bus_we stay unchanged.
- R8: When interrupt enable is 1, irq goes high for exactly one cycle, right after the edge that acknowledges the final write. When interrupt enable is 0, irq stays low.
- R9: Without repeat, the enable bit reads 0 right after the final write is acknowledged. The working source and destination return to their last loaded values, so a later enable starts from those addresses.
- R10: With repeat, enable stays 1 after a run and the channel re-arms without the guard delay. The source and destination continue from where they stopped, except that destination mode 11 reloads the destination from its loaded value at each start.
- R11: Writing the control word with enable 0 stops the channel: bus_req is low right after that edge and stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 count |
| cfg_wdata | input | AW (32) | Register write data |
| ctrl_rdata | output | 16 | Current control word |
| vblank_evt | input | 1 | Vertical-blank start event |
| hblank_evt | input | 1 | Horizontal-blank start event |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access, 0 = read access |
| bus_wide | output | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_addr | output | AW (32) | Byte address of the access |
| bus_wdata | output | DW (32) | Write data |
| bus_rdata | input | DW (32) | Read data, valid with bus_ack on a read |
| bus_ack | input | 1 | Access accepted this cycle |
| irq | output | 1 | Transfer-complete interrupt pulse |

## Verification
The assertions check on every cycle that:
- the request, address and direction hold steady until acknowledge;
- the bus stays idle during the two guard cycles, under start select 11, and after a disabling write;
- irq is a single-cycle pulse that only ever follows a set interrupt-enable bit;
- enable clears or stays set after a run according to the repeat bit.

Only the bench scenarios can show the data-dependent results: the address sequences produced by each mode and unit size, the count of units moved, the data placed on the halfword lane, the restore of addresses at completion, and the carry-on versus reload behaviour between repeat runs.

// File: rtl/dma_pkg.sv
// Shared types for the DMA channel.
// Assumes the control word layout is fixed. The packed control struct maps
// exactly onto control bits 15:6, and bits 5:0 are reserved.
package dma_pkg;

    typedef enum logic [1:0] {
        AM_UP        = 2'b00,
        AM_DOWN      = 2'b01,
        AM_HOLD      = 2'b10,
        AM_UP_RELOAD = 2'b11
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_NOW = 2'b00,
        ST_VBL = 2'b01,
        ST_HBL = 2'b10,
        ST_BAD = 2'b11
    } start_sel_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_SRC  = 2'd1,
        SEL_DST  = 2'd2,
        SEL_CNT  = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ARMED,
        SQ_READ,
        SQ_WRITE
    } seq_state_e;

    // Control word fields, most significant first (bits 15 down to 6).
    typedef struct packed {
        logic       en;
        logic       irq_en;
        start_sel_e start;
        logic       wide;
        logic       rpt;
        addr_mode_e src_mode;
        addr_mode_e dst_mode;
    } ctrl_t;

    localparam int CTRL_W     = 16;
    localparam int CTRL_RSV_W = CTRL_W - $bits(ctrl_t);

endpackage

// File: rtl/dma_addr_unit.sv
// Working address register with per-unit stepping.
// Assumes load and step may both be high in the same cycle; load wins.
// IS_DST selects how mode 11 is read: the destination steps up, the source holds.
module dma_addr_unit
    import dma_pkg::*;
#(
    parameter int AW     = 32,
    parameter bit IS_DST = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  addr_mode_e    mode,
    input  logic          wide,
    output logic [AW-1:0] addr
);

    localparam logic [AW-1:0] HALF_STRIDE = AW'(2);
    localparam logic [AW-1:0] WORD_STRIDE = AW'(4);

    addr_mode_e    eff_mode;
    logic [AW-1:0] stride;
    logic [AW-1:0] addr_next;

    // Map the shared code 11 onto the behaviour this direction needs.
    generate
        if (IS_DST) begin : g_dst
            always_comb eff_mode = (mode == AM_UP_RELOAD) ? AM_UP : mode;
        end else begin : g_src
            always_comb eff_mode = (mode == AM_UP_RELOAD) ? AM_HOLD : mode;
        end
    endgenerate

    assign stride = wide ? WORD_STRIDE : HALF_STRIDE;

    // Next address after one unit has moved.
    always_comb begin
        unique case (eff_mode)
            AM_UP:   addr_next = addr + stride;
            AM_DOWN: addr_next = addr - stride;
            default: addr_next = addr;
        endcase
    end

    // Address register: load from software or restore, otherwise step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step) begin
            addr <= addr_next;
        end
    end

endmodule

// File: rtl/dma_start_gate.sv
// Start-condition gate: applies the guard delay after enable and picks the start event.
// Assumes arm is a single-cycle pulse on the edge where enable goes from 0 to 1.
module dma_start_gate
    import dma_pkg::*;
#(
    parameter int ARM_DLY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       en,
    input  start_sel_e start,
    input  logic       vblank_evt,
    input  logic       hblank_evt,
    output logic       fire
);

    localparam int DLY_W = $clog2(ARM_DLY + 1);

    logic [DLY_W-1:0] guard_cnt;
    logic             evt;

    // Count down the guard window that follows each enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            guard_cnt <= '0;
        end else if (arm) begin
            guard_cnt <= DLY_W'(ARM_DLY);
        end else if (guard_cnt != '0) begin
            guard_cnt <= guard_cnt - 1'b1;
        end
    end

    // Select the start event named by the control word.
    always_comb begin
        unique case (start)
            ST_NOW:  evt = 1'b1;
            ST_VBL:  evt = vblank_evt;
            ST_HBL:  evt = hblank_evt;
            default: evt = 1'b0;
        endcase
    end

    assign fire = en && !arm && (guard_cnt == '0) && evt;

endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: idle, armed, then a read/write pair for each unit.
// Assumes en already includes the effect of a disabling control write made
// in the same cycle.
module dma_seq
    import dma_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fire,
    input  logic          rpt,
    input  logic          irq_en,
    input  logic          bus_ack,
    input  logic [CW-1:0] cnt_prog,
    output seq_state_e    state,
    output logic          rd_ack,
    output logic          wr_ack,
    output logic          run_start,
    output logic          run_done,
    output logic          irq
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] remain;

    assign rd_ack    = en && (state == SQ_READ) && bus_ack;
    assign wr_ack    = en && (state == SQ_WRITE) && bus_ack;
    assign run_start = en && (state == SQ_ARMED) && fire;
    assign run_done  = wr_ack && (remain == ONE);

    // State register: walk through arm, read and write; drop to idle when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else if (!en) begin
            state <= SQ_IDLE;
        end else begin
            unique case (state)
                SQ_IDLE:  state <= SQ_ARMED;
                SQ_ARMED: if (fire) state <= SQ_READ;
                SQ_READ:  if (bus_ack) state <= SQ_WRITE;
                SQ_WRITE: if (bus_ack) state <= run_done ? (rpt ? SQ_ARMED : SQ_IDLE) : SQ_READ;
                default:  state <= SQ_IDLE;
            endcase
        end
    end

    // Units still to move in this run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (run_start) begin
            remain <= cnt_prog;
        end else if (wr_ack && !run_done) begin
            remain <= remain - ONE;
        end
    end

    // One-cycle completion interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= run_done && irq_en;
        end
    end

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_start_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_READ && $past(state) != SQ_READ && $past(state) != SQ_WRITE)
            |-> $past(fire));

endmodule

// File: rtl/dma_chan.sv
// One DMA channel: programmable registers, start gate, sequencer and two address units.
// Assumes a single bus master port with a request/acknowledge handshake and
// one outstanding access at a time. A 16-bit unit uses data bits DW/2-1:0.
module dma_chan
    import dma_pkg::*;
#(
    parameter int AW      = 32,
    parameter int DW      = 32,
    parameter int CW      = 16,
    parameter int ARM_DLY = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [15:0]   ctrl_rdata,
    input  logic          vblank_evt,
    input  logic          hblank_evt,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_wide,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          irq
);

    localparam int HW = DW / 2;

    ctrl_t         ctrl;
    logic [AW-1:0] src_prog;
    logic [AW-1:0] dst_prog;
    logic [CW-1:0] cnt_prog;
    logic [DW-1:0] rd_buf;

    logic          wr_ctrl, wr_src, wr_dst, wr_cnt;
    logic          arm, kill, en_eff, fire;
    logic          rd_ack, wr_ack, run_start, run_done, restore, running;
    logic          src_load, dst_load;
    logic [AW-1:0] src_addr, dst_addr, src_load_val, dst_load_val;
    seq_state_e    state;

    assign wr_ctrl = cfg_wr && (cfg_sel == SEL_CTRL);
    assign wr_src  = cfg_wr && (cfg_sel == SEL_SRC);
    assign wr_dst  = cfg_wr && (cfg_sel == SEL_DST);
    assign wr_cnt  = cfg_wr && (cfg_sel == SEL_CNT);
    assign arm     = wr_ctrl && cfg_wdata[CTRL_W-1] && !ctrl.en;
    assign kill    = wr_ctrl && !cfg_wdata[CTRL_W-1];
    assign en_eff  = ctrl.en && !kill;
    assign running = (state == SQ_READ) || (state == SQ_WRITE);
    assign restore = run_done && !ctrl.rpt;

    // Control word: software writes win; a single-shot completion clears enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= ctrl_t'(cfg_wdata[CTRL_W-1:CTRL_RSV_W]);
        end else if (restore) begin
            ctrl.en <= 1'b0;
        end
    end

    // Programmed addresses and count, as last written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prog <= '0;
            dst_prog <= '0;
            cnt_prog <= '0;
        end else begin
            if (wr_src) src_prog <= cfg_wdata;
            if (wr_dst) dst_prog <= cfg_wdata;
            if (wr_cnt) cnt_prog <= cfg_wdata[CW-1:0];
        end
    end

    // Hold the data that was read until it is written out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf <= '0;
        end else if (rd_ack) begin
            rd_buf <= bus_rdata;
        end
    end

    assign ctrl_rdata = {ctrl, {CTRL_RSV_W{1'b0}}};

    assign src_load     = (wr_src && !running) || restore;
    assign src_load_val = wr_src ? cfg_wdata : src_prog;
    assign dst_load     = (wr_dst && !running) || restore
                        || (run_start && ctrl.dst_mode == AM_UP_RELOAD);
    assign dst_load_val = wr_dst ? cfg_wdata : dst_prog;

    dma_start_gate #(
        .ARM_DLY (ARM_DLY)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .en         (en_eff),
        .start      (ctrl.start),
        .vblank_evt (vblank_evt),
        .hblank_evt (hblank_evt),
        .fire       (fire)
    );

    dma_seq #(
        .CW (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en_eff),
        .fire      (fire),
        .rpt       (ctrl.rpt),
        .irq_en    (ctrl.irq_en),
        .bus_ack   (bus_ack),
        .cnt_prog  (cnt_prog),
        .state     (state),
        .rd_ack    (rd_ack),
        .wr_ack    (wr_ack),
        .run_start (run_start),
        .run_done  (run_done),
        .irq       (irq)
    );

    dma_addr_unit #(
        .AW     (AW),
        .IS_DST (1'b0)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (src_load),
        .load_val (src_load_val),
        .step     (rd_ack),
        .mode     (ctrl.src_mode),
        .wide     (ctrl.wide),
        .addr     (src_addr)
    );

    dma_addr_unit #(
        .AW     (AW),
        .IS_DST (1'b1)
    ) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dst_load),
        .load_val (dst_load_val),
        .step     (wr_ack),
        .mode     (ctrl.dst_mode),
        .wide     (ctrl.wide),
        .addr     (dst_addr)
    );

    assign bus_req   = running;
    assign bus_we    = (state == SQ_WRITE);
    assign bus_wide  = ctrl.wide;
    assign bus_addr  = bus_we ? dst_addr : src_addr;
    assign bus_wdata = ctrl.wide ? rd_buf : {{(DW-HW){1'b0}}, rd_buf[HW-1:0]};

    p_guard_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm) |-> !bus_req);

    p_guard_second_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(arm, 2) |-> !bus_req);

    p_bad_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.start == ST_BAD && !bus_req) |=> !bus_req);

    p_hold_until_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !wr_ctrl) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ctrl.irq_en));

    p_self_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && !ctrl.rpt && !wr_ctrl) |=> !ctrl_rdata[15]);

    p_stay_armed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_done && ctrl.rpt && !wr_ctrl) |=> ctrl_rdata[15]);

    p_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> !bus_req);

endmodule

// File: tb/dma_chan_bench.sv
// Directed bench for dma_chan: one task per scenario, each checking its own results.
module dma_chan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] ctrl_rdata;
    logic        vblank_evt = 1'b0;
    logic        hblank_evt = 1'b0;
    logic        bus_req, bus_we, bus_wide, irq;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    logic [31:0] lg_addr [0:255];
    logic [31:0] lg_data [0:255];
    logic        lg_we   [0:255];
    logic        lg_wide [0:255];
    int          lg_n = 0;
    int          irq_total = 0;
    int          irq_run = 0;
    int          irq_maxrun = 0;

    always #4 clk = ~clk;

    dma_chan u_dma_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .ctrl_rdata (ctrl_rdata),
        .vblank_evt (vblank_evt),
        .hblank_evt (hblank_evt),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_wide   (bus_wide),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .irq        (irq)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {~a[15:0], a[15:0]};
    endfunction

    function automatic logic [31:0] mk(input logic en, input logic ie, input logic [1:0] st,
                                       input logic wd, input logic rp,
                                       input logic [1:0] sm, input logic [1:0] dm);
        return {16'h0, en, ie, st, wd, rp, sm, dm, 6'b0};
    endfunction

    // Memory model: acknowledge every other cycle, log each access, watch irq.
    always @(negedge clk) begin
        if (bus_req && !bus_ack) begin
            bus_ack   <= 1'b1;
            bus_rdata <= mem_word(bus_addr);
            if (lg_n < 256) begin
                lg_addr[lg_n] = bus_addr;
                lg_data[lg_n] = bus_we ? bus_wdata : mem_word(bus_addr);
                lg_we[lg_n]   = bus_we;
                lg_wide[lg_n] = bus_wide;
                lg_n          = lg_n + 1;
            end
        end else begin
            bus_ack <= 1'b0;
        end
        if (irq) begin
            irq_total = irq_total + 1;
            irq_run   = irq_run + 1;
            if (irq_run > irq_maxrun) irq_maxrun = irq_run;
        end else begin
            irq_run = 0;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_disabled();
        for (int i = 0; i < 3000 && ctrl_rdata[15]; i++) idle(1);
        idle(3);
    endtask

    task automatic wait_irq(input int target);
        for (int i = 0; i < 3000 && irq_total < target; i++) idle(1);
        idle(3);
    endtask

    task automatic pulse(input logic v, input logic h);
        vblank_evt = v; hblank_evt = h;
        idle(1);
        vblank_evt = 1'b0; hblank_evt = 1'b0;
    endtask

    task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        cfg_write(2'd1, s);
        cfg_write(2'd2, d);
        cfg_write(2'd3, c);
    endtask

    task automatic t_reset();
        chk("R1", "ctrl after reset", {16'h0, ctrl_rdata}, 32'h0);
        chk("R1", "bus_req after reset", {31'h0, bus_req}, 32'h0);
        chk("R1", "irq after reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_readback();
        cfg_write(2'd0, mk(1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 2'd3, 2'd3));
        chk("R2", "all fields readback", {16'h0, ctrl_rdata}, 32'h7FC0);
        cfg_write(2'd0, 32'h0000_7FFF);
        chk("R2", "reserved bits read 0", {16'h0, ctrl_rdata}, 32'h7FC0);
        cfg_write(2'd0, 32'h0);
        chk("R2", "cleared", {16'h0, ctrl_rdata}, 32'h0);
    endtask

    task automatic t_now_half();
        int b, ib, n;
        load(32'h100, 32'h200, 32'd3);
        b = lg_n; ib = irq_total; irq_maxrun = 0;
        cfg_write(2'd0, mk(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0));
        n = 0;
        while (!bus_req && n < 20) begin idle(1); n++; end
        chk("R3", "edges from enable to first request", n, 3);
        wait_disabled();
        chk("R7", "access count for 3 units", lg_n - b, 6);
        for (int k = 0; k < 3; k++) begin
            chk("R5", "read is a read", {31'h0, lg_we[b+2*k]}, 32'h0);
            chk("R6", "source steps up by 2", lg_addr[b+2*k], 32'h100 + 2*k);
            chk("R5", "halfword size", {31'h0, lg_wide[b+2*k+1]}, 32'h0);
            chk("R6", "destination steps up by 2", lg_addr[b+2*k+1], 32'h200 + 2*k);
            chk("R5", "halfword lane data", lg_data[b+2*k+1], {16'h0, 16'h100 + 16'(2*k)});
        end
        chk("R8", "one irq", irq_total - ib, 1);
        chk("R8", "irq width", irq_maxrun, 1);
        chk("R9", "enable self-cleared", {16'h0, ctrl_rdata}, 32'h4000);
    endtask

    task automatic t_restore();
        int b;
        b = lg_n;
        cfg_write(2'd0, mk(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0));
        wait_disabled();
        chk("R9", "source restored", lg_addr[b], 32'h100);
        chk("R9", "destination restored", lg_addr[b+1], 32'h200);
    endtask

    task automatic t_word_dec_hold();
        int b, ib;
        load(32'h300, 32'h400, 32'd2);
        b = lg_n; ib = irq_total;
        cfg_write(2'd0, mk(1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 2'd1, 2'd2));
        wait_disabled();
        chk("R7", "access count for 2 units", lg_n - b, 4);
        chk("R6", "source first", lg_addr[b], 32'h300);
        chk("R6", "source steps down by 4", lg_addr[b+2], 32'h2FC);
        chk("R6", "destination held first", lg_addr[b+1], 32'h400);
        chk("R6", "destination held second", lg_addr[b+3], 32'h400);
        chk("R5", "word size", {31'h0, lg_wide[b+1]}, 32'h1);
        chk("R5", "word data first", lg_data[b+1], mem_word(32'h300));
        chk("R5", "word data second", lg_data[b+3], mem_word(32'h2FC));
        chk("R8", "no irq when disabled", irq_total - ib, 0);
    endtask

    task automatic t_vblank();
        int b;
        load(32'h10, 32'h20, 32'd1);
        b = lg_n;
        vblank_evt = 1'b1;
        cfg_write(2'd0, mk(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0, 2'd0));
        @(posedge clk); @(posedge clk); #1;
        vblank_evt = 1'b0;
        idle(8);
        chk("R3", "events inside guard ignored", lg_n - b, 0);
        pulse(1'b0, 1'b1);
        idle(6);
        chk("R4", "hblank ignored under vblank select", lg_n - b, 0);
        pulse(1'b1, 1'b0);
        wait_disabled();
        chk("R4", "vblank starts transfer", lg_n - b, 2);
        chk("R4", "vblank run destination", lg_addr[b+1], 32'h20);
    endtask

    task automatic t_rpt_reload();
        int b, ib;
        load(32'h500, 32'h600, 32'd2);
        ib = irq_total;
        cfg_write(2'd0, mk(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 2'd0, 2'd3));
        idle(4);
        b = lg_n;
        pulse(1'b0, 1'b1);
        wait_irq(ib + 1);
        chk("R10", "enable stays set", {31'h0, ctrl_rdata[15]}, 32'h1);
        chk("R10", "first run source", lg_addr[b+2], 32'h502);
        chk("R10", "first run destination", lg_addr[b+3], 32'h602);
        b = lg_n;
        pulse(1'b0, 1'b1);
        wait_irq(ib + 2);
        chk("R10", "second run count", lg_n - b, 4);
        chk("R10", "source carries on", lg_addr[b], 32'h504);
        chk("R10", "destination reloaded", lg_addr[b+1], 32'h600);
        chk("R10", "reloaded destination steps", lg_addr[b+3], 32'h602);
        cfg_write(2'd0, 32'h0);
        idle(2);
    endtask

    task automatic t_rpt_carry();
        int b, ib;
        load(32'h800, 32'h700, 32'd1);
        ib = irq_total;
        cfg_write(2'd0, mk(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 2'd3, 2'd0));
        idle(4);
        b = lg_n;
        pulse(1'b0, 1'b1);
        wait_irq(ib + 1);
        pulse(1'b0, 1'b1);
        wait_irq(ib + 2);
        chk("R6", "source mode 11 holds", lg_addr[b+2], 32'h800);
        chk("R10", "destination carries on", lg_addr[b+3], 32'h702);
        cfg_write(2'd0, 32'h0);
        idle(2);
    endtask

    task automatic t_bad_start();
        int b;
        load(32'h40, 32'h80, 32'd1);
        b = lg_n;
        cfg_write(2'd0, mk(1'b1, 1'b0, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0));
        idle(4);
        pulse(1'b1, 1'b1);
        idle(20);
        chk("R4", "code 11 never starts", lg_n - b, 0);
        cfg_write(2'd0, 32'h0);
    endtask

    task automatic t_stop();
        int b;
        load(32'h900, 32'hA00, 32'd50);
        cfg_write(2'd0, mk(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0));
        idle(12);
        cfg_write(2'd0, 32'h0);
        chk("R11", "request low after stop", {31'h0, bus_req}, 32'h0);
        b = lg_n;
        idle(10);
        chk("R11", "no access after stop", lg_n - b, 0);
        chk("R11", "request stays low", {31'h0, bus_req}, 32'h0);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors = errors + 1;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_readback();
        t_now_half();
        t_restore();
        t_word_dec_hold();
        t_vblank();
        t_rpt_reload();
        t_rpt_carry();
        t_bad_start();
        t_stop();
        summary();
    end

endmodule